// File: doc/BRIEF.md
# Serial Port Host Register File

This block is the host-side register set of a byte-wide serial port. The host reaches it through a small bus: a 3-bit offset, a write strobe, a read strobe, write data, and read data that comes back one cycle later. A byte that the host writes to the data offset leaves the block as a one-cycle valid pulse on the transmit port. Bytes that arrive from the line side enter through a push port and wait in a receive queue until the host reads them. The block does no baud generation and no serial framing. It has no transmit queue, so the transmitter always reports empty.

The block holds the line control, modem control, scratch and two divisor registers. The top bit of line control switches offsets 0 and 1 over to the two divisor bytes. A modem control bit turns on internal loopback: host transmit writes go into the receive queue and do not reach the transmit port. A receive cause and a transmit cause feed one interrupt line, and the identification offset reports which cause is active. The receive cause takes priority.

The transmit cause is a two-state machine. In `TXE_IDLE` no transmit interrupt is waiting. It moves to `TXE_PENDING` on a set event: either an interrupt-enable write with bit 1 set, or an emitted transmit write while that enable is on. It returns to `TXE_IDLE` on a clear event, which is an identification read that reports the transmit cause. If a set event and a clear event fall in the same cycle, the set wins.

Top module: `serial_host_regs`

## Requirements
- R1: After reset every register reads 0, the receive queue is empty, irq and tx_valid are low, and offset 2 reads 0x01.
- R2: While line control bit 7 is 1, offsets 0 and 1 read and write the low and high divisor bytes. A write to offset 0 in this state does not raise tx_valid.
- R3: While line control bit 7 is 0 and modem control bit 4 is 0, a write to offset 0 raises tx_valid for exactly one cycle, the cycle after the write strobe edge, with tx_data equal to the written byte.
- R4: While line control bit 7 is 0, a read of offset 0 returns the oldest queued byte and removes it. It returns 0 when the queue is empty. All read data appears on bus_rdata in the cycle after the read strobe edge.
- R5: The receive queue holds 16 bytes. A push while the queue is full is dropped. A push and a pop in the same cycle both take effect, including when the queue is full.
- R6: Offset 1 (while line control bit 7 is 0) is the interrupt enable: bit 0 enables the receive cause and bit 1 enables the transmit cause. Writing it with bit 1 set enters `TXE_PENDING`. A transmit write that is emitted while bit 1 is set also enters `TXE_PENDING`.
- R7: A read of offset 2 returns 0x04 if the receive cause is enabled and the queue is not empty. Otherwise it returns 0x02 if the transmit cause is enabled and pending, and that read returns the machine to `TXE_IDLE`. Otherwise it returns 0x01.
- R8: irq is high exactly while (enable bit 0 and queue not empty) or (enable bit 1 and `TXE_PENDING`). An identification read does not clear the receive cause.
- R9: While modem control bit 4 is 1, a transmit write at offset 0 pushes the byte into the receive queue and does not raise tx_valid.
- R10: Offset 5 reads 0x60 with bit 0 set when the receive queue is not empty.
- R11: Offset 6 always reads 0xB0. Offsets 3, 4 and 7 read back the last value written to them. Writes to offsets 2, 5 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| tx_valid | output | 1 | Transmit byte valid pulse |
| tx_data | output | 8 | Transmit byte |
| rx_push | input | 1 | Receive byte push |
| rx_byte | input | 8 | Receive byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a push and a pop in the same cycle on a full queue. The stimulus first fills the queue past its depth, then drives a push together with a data read, and then drains the queue to confirm that both the extra byte and the arrival order survive. The transmit-pending clear also needs a receive cause that has been masked first, so the directed sequence runs through enable changes before the long random phase of mixed reads, writes, pushes and loopback.

// File: rtl/serial_regs_pkg.sv
package serial_regs_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [2:0] {
        OFS_DATA    = 3'd0,
        OFS_IEN     = 3'd1,
        OFS_IDENT   = 3'd2,
        OFS_LCTL    = 3'd3,
        OFS_MCTL    = 3'd4,
        OFS_LSTAT   = 3'd5,
        OFS_MSTAT   = 3'd6,
        OFS_SCRATCH = 3'd7
    } ofs_e;

    typedef enum logic {
        TXE_IDLE,
        TXE_PENDING
    } txe_state_e;

    localparam logic [DATA_W-1:0] ID_RX       = 8'h04;
    localparam logic [DATA_W-1:0] ID_TX       = 8'h02;
    localparam logic [DATA_W-1:0] ID_NONE     = 8'h01;
    localparam logic [DATA_W-1:0] MSTAT_VALUE = 8'hB0;
    localparam logic [DATA_W-1:0] LSTAT_BASE  = 8'h60;

    localparam int LCTL_DIV_BIT  = 7;
    localparam int MCTL_LOOP_BIT = 4;
    localparam int IEN_RX_BIT    = 0;
    localparam int IEN_TX_BIT    = 1;
endpackage

// File: rtl/sr_rx_fifo.sv
module sr_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_pop, do_push;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // A pop on an empty queue does nothing. A push into a full queue
    // is accepted only if a pop frees a slot in the same cycle.
    assign do_pop  = pop && (cnt_q != '0);
    assign do_push = push && ((cnt_q != FULL_CNT) || do_pop);

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (cnt_q == '0);
    assign count = cnt_q;
endmodule

// File: rtl/sr_txe_fsm.sv
module sr_txe_fsm
    import serial_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic pending
);
    txe_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TXE_IDLE;
        else        state_q <= state_d;
    end

    // A set event in the same cycle as a clear event wins.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXE_IDLE:    if (set_evt) state_d = TXE_PENDING;
            TXE_PENDING: if (clr_evt && !set_evt) state_d = TXE_IDLE;
            default:     state_d = TXE_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == TXE_PENDING);
    end
endmodule

// File: rtl/sr_intr_ident.sv
module sr_intr_ident
    import serial_regs_pkg::*;
(
    input  logic              rx_en,
    input  logic              rx_ready,
    input  logic              tx_en,
    input  logic              tx_pend,
    output logic [DATA_W-1:0] ident,
    output logic              tx_chosen,
    output logic              irq
);
    logic rx_cause, tx_cause;

    assign rx_cause = rx_en && rx_ready;
    assign tx_cause = tx_en && tx_pend;

    // The receive cause always outranks the transmit cause.
    always_comb begin
        tx_chosen = 1'b0;
        if (rx_cause) begin
            ident = ID_RX;
        end else if (tx_cause) begin
            ident     = ID_TX;
            tx_chosen = 1'b1;
        end else begin
            ident = ID_NONE;
        end
    end

    assign irq = rx_cause || tx_cause;
endmodule

// File: rtl/serial_host_regs.sv
module serial_host_regs
    import serial_regs_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              irq
);
    ofs_e              ofs;
    logic [DATA_W-1:0] ien_q, lctl_q, mctl_q, scr_q, div_lo_q, div_hi_q;
    logic [DATA_W-1:0] rdata_q, rd_mux;
    logic [DATA_W-1:0] tx_data_q;
    logic              tx_valid_q;

    logic              div_sel, loop_on;
    logic              wr_data, emit, loop_wr, rd_pop;
    logic              fifo_push;
    logic [DATA_W-1:0] fifo_push_data, fifo_head;
    logic              rx_empty;
    logic [CNT_W-1:0]  rx_count;
    logic              txe_set, txe_clr, txe_pend;
    logic [DATA_W-1:0] ident;
    logic              ident_tx;

    assign ofs     = ofs_e'(bus_addr);
    assign div_sel = lctl_q[LCTL_DIV_BIT];
    assign loop_on = mctl_q[MCTL_LOOP_BIT];

    assign wr_data = bus_wr && (ofs == OFS_DATA) && !div_sel;
    assign emit    = wr_data && !loop_on;
    assign loop_wr = wr_data && loop_on;
    assign rd_pop  = bus_rd && (ofs == OFS_DATA) && !div_sel;

    // A loopback write takes the queue's input in place of the push port.
    assign fifo_push      = loop_wr || rx_push;
    assign fifo_push_data = loop_wr ? bus_wdata : rx_byte;

    sr_rx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (DATA_W)
    ) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (fifo_push_data),
        .pop       (rd_pop),
        .head      (fifo_head),
        .empty     (rx_empty),
        .count     (rx_count)
    );

    sr_intr_ident u_ident (
        .rx_en     (ien_q[IEN_RX_BIT]),
        .rx_ready  (!rx_empty),
        .tx_en     (ien_q[IEN_TX_BIT]),
        .tx_pend   (txe_pend),
        .ident     (ident),
        .tx_chosen (ident_tx),
        .irq       (irq)
    );

    assign txe_set = (bus_wr && (ofs == OFS_IEN) && !div_sel && bus_wdata[IEN_TX_BIT])
                  || (emit && ien_q[IEN_TX_BIT]);
    assign txe_clr = bus_rd && (ofs == OFS_IDENT) && ident_tx;

    sr_txe_fsm u_txe (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (txe_set),
        .clr_evt (txe_clr),
        .pending (txe_pend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q    <= '0;
            lctl_q   <= '0;
            mctl_q   <= '0;
            scr_q    <= '0;
            div_lo_q <= '0;
            div_hi_q <= '0;
        end else if (bus_wr) begin
            unique case (ofs)
                OFS_DATA:    if (div_sel) div_lo_q <= bus_wdata;
                OFS_IEN:     if (div_sel) div_hi_q <= bus_wdata;
                             else         ien_q    <= bus_wdata;
                OFS_LCTL:    lctl_q <= bus_wdata;
                OFS_MCTL:    mctl_q <= bus_wdata;
                OFS_SCRATCH: scr_q  <= bus_wdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_DATA:    rd_mux = div_sel ? div_lo_q : (rx_empty ? '0 : fifo_head);
            OFS_IEN:     rd_mux = div_sel ? div_hi_q : ien_q;
            OFS_IDENT:   rd_mux = ident;
            OFS_LCTL:    rd_mux = lctl_q;
            OFS_MCTL:    rd_mux = mctl_q;
            OFS_LSTAT:   rd_mux = LSTAT_BASE | {{(DATA_W-1){1'b0}}, !rx_empty};
            OFS_MSTAT:   rd_mux = MSTAT_VALUE;
            OFS_SCRATCH: rd_mux = scr_q;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            tx_valid_q <= 1'b0;
            tx_data_q  <= '0;
        end else begin
            if (bus_rd) rdata_q <= rd_mux;
            tx_valid_q <= emit;
            if (emit) tx_data_q <= bus_wdata;
        end
    end

    assign bus_rdata = rdata_q;
    assign tx_valid  = tx_valid_q;
    assign tx_data   = tx_data_q;
endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [7:0]       bus_rdata,
    input logic             tx_valid,
    input logic             irq,
    input logic [7:0]       lctl_q,
    input logic [7:0]       mctl_q,
    input logic [7:0]       ien_q,
    input logic             txe_pend,
    input logic             rx_empty,
    input logic [CNT_W-1:0] rx_count
);
    p_div_no_emit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && lctl_q[7]) |=> !tx_valid);

    p_emit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && !lctl_q[7] && !mctl_q[4]) |=> tx_valid);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CNT_W'(FIFO_DEPTH));

    p_ident_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == 3'd2 && ien_q[1] && txe_pend
         && !(ien_q[0] && !rx_empty)) |=> !txe_pend);

    p_rx_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd2 && ien_q[0] && !rx_empty) |=> bus_rdata == 8'h04);

    p_irq_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q[0] && !rx_empty) |-> irq);

    p_loop_no_emit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && !lctl_q[7] && mctl_q[4]) |=> !tx_valid);

    p_lstat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd5) |=>
            (bus_rdata[6:5] == 2'b11 && bus_rdata[0] == !$past(rx_empty)));

    p_mstat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd6) |=> bus_rdata == 8'hB0);
endmodule

bind serial_host_regs sr_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_sr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .irq       (irq),
    .lctl_q    (lctl_q),
    .mctl_q    (mctl_q),
    .ien_q     (ien_q),
    .txe_pend  (txe_pend),
    .rx_empty  (rx_empty),
    .rx_count  (rx_count)
);

// File: tb/serial_host_regs_bench.sv
module serial_host_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] bus_addr;
    logic       bus_wr, bus_rd, rx_push;
    logic [7:0] bus_wdata, rx_byte;
    logic [7:0] bus_rdata, tx_data;
    logic       tx_valid, irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference state kept by the bench
    logic [7:0] m_ier, m_lcr, m_mcr, m_scr, m_dll, m_dlm;
    bit         m_pend;
    logic [7:0] q[$];
    string      tag_force = "";

    always #10 clk = ~clk;

    serial_host_regs u_serial_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_push(rx_push),
        .rx_byte(rx_byte), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [2:0] a);
        bit dl = m_lcr[7];
        case (a)
            3'd0: return dl ? m_dll : (q.size() > 0 ? q[0] : 8'h00);
            3'd1: return dl ? m_dlm : m_ier;
            3'd2: begin
                if (m_ier[0] && q.size() > 0) return 8'h04;
                if (m_ier[1] && m_pend)       return 8'h02;
                return 8'h01;
            end
            3'd3: return m_lcr;
            3'd4: return m_mcr;
            3'd5: return 8'h60 | {7'd0, q.size() > 0};
            3'd6: return 8'hB0;
            default: return m_scr;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        case (a)
            3'd0: return m_lcr[7] ? "R2" : "R4";
            3'd1: return m_lcr[7] ? "R2" : "R6";
            3'd2: return "R7";
            3'd5: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic step(input bit wr, input bit rd, input logic [2:0] a,
                        input logic [7:0] wd, input bit push, input logic [7:0] pb);
        logic [7:0] exp_rd;
        bit         exp_tv, dl, lp, popped, lb;
        string      rtag, ttag;
        int         pre;
        dl     = m_lcr[7];
        lp     = m_mcr[4];
        exp_rd = model_read(a);
        rtag   = (tag_force != "") ? tag_force : read_tag(a);
        exp_tv = wr && a == 3'd0 && !dl && !lp;
        lb     = wr && a == 3'd0 && !dl && lp;
        ttag   = lb ? "R9" : (wr && a == 3'd0 && dl) ? "R2" : "R3";
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        rx_push = push; rx_byte = pb;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; rx_push = 0;
        // update the reference state
        pre    = q.size();
        popped = 0;
        if (rd && a == 3'd0 && !dl && pre > 0) begin
            void'(q.pop_front());
            popped = 1;
        end
        if (rd && a == 3'd2 && exp_rd == 8'h02) m_pend = 0;
        if (lb || push) begin
            if (pre < 16 || popped) q.push_back(lb ? wd : pb);
        end
        if (wr) begin
            case (a)
                3'd0: if (dl) m_dll = wd; else if (!lp && m_ier[1]) m_pend = 1;
                3'd1: if (dl) m_dlm = wd; else begin m_ier = wd; if (wd[1]) m_pend = 1; end
                3'd3: m_lcr = wd;
                3'd4: m_mcr = wd;
                3'd7: m_scr = wd;
                default: ;
            endcase
        end
        if (rd) check(rtag, bus_rdata, exp_rd);
        check(ttag, {7'd0, tx_valid}, {7'd0, exp_tv});
        if (exp_tv) check("R3", tx_data, wd);
        check("R8", {7'd0, irq},
              {7'd0, (m_ier[0] && q.size() > 0) || (m_ier[1] && m_pend)});
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
        step(1, 0, a, v, 0, 8'h00);
    endtask
    task automatic rd_reg(input logic [2:0] a);
        step(0, 1, a, 8'h00, 0, 8'h00);
    endtask
    task automatic push_b(input logic [7:0] b);
        step(0, 0, 3'd0, 8'h00, 1, b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        rst_n = 0; bus_wr = 0; bus_rd = 0; rx_push = 0;
        bus_addr = 0; bus_wdata = 0; rx_byte = 0;
        m_ier = 0; m_lcr = 0; m_mcr = 0; m_scr = 0; m_dll = 0; m_dlm = 0; m_pend = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: state just after reset
        check("R1", {7'd0, irq}, 8'h00);
        check("R1", {7'd0, tx_valid}, 8'h00);
        tag_force = "R1";
        for (int i = 0; i < 8; i++) rd_reg(i[2:0]);
        tag_force = "";

        // R3: plain transmit
        wr_reg(3'd0, 8'h4B);
        wr_reg(3'd0, 8'h0A);
        step(0, 0, 3'd0, 8'h00, 0, 8'h00);

        // R2: divisor access
        wr_reg(3'd3, 8'h80);
        wr_reg(3'd0, 8'h01);
        wr_reg(3'd1, 8'h00);
        rd_reg(3'd0);
        rd_reg(3'd1);
        wr_reg(3'd3, 8'h00);
        wr_reg(3'd0, 8'h41);

        // R6 R7 R8: transmit cause
        wr_reg(3'd1, 8'h02);
        rd_reg(3'd2);
        rd_reg(3'd2);
        wr_reg(3'd0, 8'h7A);
        rd_reg(3'd2);

        // R7: receive outranks transmit
        wr_reg(3'd1, 8'h03);
        push_b(8'h72);
        rd_reg(3'd2);
        rd_reg(3'd2);
        rd_reg(3'd0);
        rd_reg(3'd2);
        wr_reg(3'd1, 8'h00);

        // R9: loopback
        wr_reg(3'd4, 8'h10);
        wr_reg(3'd0, 8'h4C);
        rd_reg(3'd5);
        rd_reg(3'd0);
        wr_reg(3'd4, 8'h00);

        // R5: full queue, dropped push, simultaneous push and pop
        for (int i = 0; i < 17; i++) push_b(8'h10 + i[7:0]);
        rd_reg(3'd5);
        tag_force = "R5";
        step(0, 1, 3'd0, 8'h00, 1, 8'hEE);
        for (int i = 0; i < 16; i++) rd_reg(3'd0);
        rd_reg(3'd0);
        tag_force = "";

        // R11: scratch and ignored writes
        wr_reg(3'd7, 8'hA5);
        rd_reg(3'd7);
        wr_reg(3'd2, 8'hFF);
        wr_reg(3'd5, 8'h00);
        wr_reg(3'd6, 8'h00);
        rd_reg(3'd2);
        rd_reg(3'd5);
        rd_reg(3'd6);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int unsigned kind = $urandom % 100;
            logic [2:0]  a    = 3'($urandom);
            logic [7:0]  v    = 8'($urandom);
            if (kind < 30) begin
                push_b(v);
            end else if (kind < 65) begin
                if (kind < 40) step(0, 1, a, 8'h00, 1, v);
                else           rd_reg(a);
            end else begin
                if (a == 3'd3) v = ($urandom % 4 == 0) ? (v | 8'h80) : (v & 8'h7F);
                if (a == 3'd4) v = ($urandom % 4 == 0) ? (v | 8'h10) : (v & 8'hEF);
                wr_reg(a, v);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule